// File: doc/BRIEF.md
# Machine-Cycle Bus Timing Sequencer

This block paces a small 8-bit processor whose instructions always last a whole number of machine cycles of four clocks each. It rotates a four-phase strobe (read, decode, execute, write) on every clock. For each machine cycle it decides whether the bus is used for an opcode fetch, an operand read, a stack read, a stack write, or nothing. It drives the matching read and write enables, the address source select and a capture strobe for read data.

The decoder supplies a three-bit instruction class during the opcode fetch. For a conditional return, it supplies the condition result during the second machine cycle. A pending interrupt line is sampled when an instruction completes; if it is high, the next sequence is the interrupt entry and not an opcode fetch. The sequencer only counts and sequences. Decode, ALU and registers live elsewhere.

Top module: `mcycle_seq`

## Requirements
- R1: `phase` is one-hot and rotates bit0 (read), bit1 (decode), bit2 (execute), bit3 (write), moving one position on every clock. Each machine cycle spans exactly these four clocks. `mcyc` counts machine cycles from 0 within an instruction and changes only after a write phase.
- R2: Reset is synchronous and active low. While it is low, `rd_en`, `wr_en`, `rd_latch`, `op_fetch` and `done` are low. After release, the block starts in phase bit0 of an opcode-fetch cycle with `mcyc` = 0.
- R3: Read-type cycles (opcode fetch, operand read, stack read) hold `rd_en` high in phases bit0 to bit2 and pulse `rd_latch` in phase bit2. Stack-write cycles raise `wr_en` only in phase bit3. `rd_en` and `wr_en` are never both high.
- R4: `op_class` is sampled only at the end of the decode phase of machine cycle 0 of a fetch sequence. Codes: 0 move, 1 load-immediate, 2 prefixed, 3 push, 4 conditional return; 5, 6 and 7 act as move. Later changes have no effect.
- R5: A move is one fetch cycle. A load-immediate is a fetch followed by a PC-addressed operand read (2 cycles).
- R6: A prefixed operation is two consecutive opcode-fetch cycles, both with `op_fetch` high.
- R7: A push is fetch, idle, stack write, stack write (4 cycles).
- R8: A conditional return samples `cond_met` at the end of the decode phase of machine cycle 1. False gives fetch then idle (2 cycles). True gives fetch, idle, stack read, stack read, idle (5 cycles).
- R9: `irq_req` is sampled in the clock where `done` is high. If it is high, the next sequence is interrupt entry: idle, idle, stack write, stack write, idle (5 cycles). This sequence has no opcode fetch, and `op_class` is ignored throughout it.
- R10: `addr_sel` encodes 0 = program counter, 1 = stack pointer, 2 = none. Idle cycles show 2, assert no enable, and still take four clocks.
- R11: `done` is a one-clock pulse in phase bit3 of the last machine cycle. The following clock is `mcyc` = 0, phase bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_class | input | 3 | Instruction class from decoder |
| cond_met | input | 1 | Condition result for conditional return |
| irq_req | input | 1 | Pending interrupt, sampled at instruction end |
| phase | output | 4 | One-hot phase strobe |
| mcyc | output | 3 | Machine-cycle index within the instruction |
| rd_en | output | 1 | Bus read enable |
| rd_latch | output | 1 | Read data capture strobe |
| wr_en | output | 1 | Bus write enable |
| addr_sel | output | 2 | Address source: 0 PC, 1 SP, 2 none |
| op_fetch | output | 1 | Current cycle is an opcode fetch |
| done | output | 1 | Last clock of the instruction |

## Verification
The bench sweeps every class code with both condition values, and runs each combination both as a normal fetch and as an interrupt entry. It compares all outputs on every clock against a cycle table worked out from the requirements.

In every run, the bench changes `op_class` and `cond_met` just after their sampling edges. A design that sampled late or read them combinationally would then pick the wrong length or slot pattern. The interrupt runs drive random classes, so a design that let the class leak into the entry sequence would insert a fetch or the wrong number of cycles.

A reset in the middle of a push checks that the enables drop at once and that the sequence restarts with a clean fetch rather than resuming the stack writes.

// File: rtl/mseq_pkg.sv
// Shared definitions for the machine-cycle sequencer: cycle kinds,
// class codes, address-source codes and the per-class cycle table.
// Assumes at most eight machine cycles per instruction.
package mseq_pkg;

    localparam int MCYC_W = 3;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_RDPC  = 3'd1,
        K_RDSP  = 3'd2,
        K_WRSP  = 3'd3,
        K_IDLE  = 3'd4
    } mkind_t;

    localparam logic [2:0] CL_MOVE = 3'd0;
    localparam logic [2:0] CL_LDI  = 3'd1;
    localparam logic [2:0] CL_PFX  = 3'd2;
    localparam logic [2:0] CL_PUSH = 3'd3;
    localparam logic [2:0] CL_RETC = 3'd4;

    localparam logic [1:0] AS_PC   = 2'd0;
    localparam logic [1:0] AS_SP   = 2'd1;
    localparam logic [1:0] AS_NONE = 2'd2;

    // Bus usage of machine cycle m for the given sequence.
    function automatic mkind_t step_kind(input logic irq, input logic [2:0] cls,
                                         input logic [MCYC_W-1:0] m);
        mkind_t k;
        k = K_IDLE;
        if (irq) begin
            k = (m == 3'd2 || m == 3'd3) ? K_WRSP : K_IDLE;
        end else if (m == 3'd0) begin
            k = K_FETCH;
        end else begin
            case (cls)
                CL_LDI:  k = K_RDPC;
                CL_PFX:  k = K_FETCH;
                CL_PUSH: k = (m == 3'd1) ? K_IDLE : K_WRSP;
                CL_RETC: k = (m == 3'd2 || m == 3'd3) ? K_RDSP : K_IDLE;
                default: k = K_IDLE;
            endcase
        end
        return k;
    endfunction

    // True when machine cycle m is the final one of the sequence.
    function automatic logic step_last(input logic irq, input logic [2:0] cls,
                                       input logic cond, input logic [MCYC_W-1:0] m);
        logic l;
        if (irq) begin
            l = (m == 3'd4);
        end else begin
            case (cls)
                CL_LDI, CL_PFX: l = (m == 3'd1);
                CL_PUSH:        l = (m == 3'd3);
                CL_RETC:        l = cond ? (m == 3'd4) : (m == 3'd1);
                default:        l = (m == 3'd0);
            endcase
        end
        return l;
    endfunction

endpackage

// File: rtl/mseq_phase.sv
// Phase counter: steps through NUM_PH phases per machine cycle, one per
// clock, and decodes a one-hot strobe. Assumes NUM_PH >= 2.
module mseq_phase #(
    parameter int NUM_PH = 4,
    localparam int PH_W  = $clog2(NUM_PH)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PH_W-1:0]   ph_idx,
    output logic [NUM_PH-1:0] ph_strobe,
    output logic              ph_last
);

    localparam logic [PH_W-1:0] LAST_IDX = PH_W'(NUM_PH - 1);

    assign ph_last = (ph_idx == LAST_IDX);

    // Advance the phase index and wrap after the final phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       ph_idx <= '0;
        else if (ph_last) ph_idx <= '0;
        else              ph_idx <= ph_idx + 1'b1;
    end

    // One strobe bit per phase.
    for (genvar i = 0; i < NUM_PH; i++) begin : g_strobe
        assign ph_strobe[i] = (ph_idx == PH_W'(i));
    end

endmodule

// File: rtl/mseq_track.sv
// Machine-cycle tracker: counts machine cycles within an instruction,
// latches the class and condition at their decode phases, and selects
// interrupt entry when requested at instruction end.
module mseq_track
    import mseq_pkg::*;
#(
    parameter int NUM_PH = 4,
    localparam int PH_W  = $clog2(NUM_PH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   ph_idx,
    input  logic              ph_last,
    input  logic [2:0]        op_class,
    input  logic              cond_met,
    input  logic              irq_req,
    output logic [MCYC_W-1:0] mcyc,
    output mkind_t            kind,
    output logic              last
);

    localparam logic [PH_W-1:0] DEC_PH = PH_W'(1);

    logic [2:0] cls_q;
    logic       cond_q;
    logic       irq_mode;

    assign kind = step_kind(irq_mode, cls_q, mcyc);
    assign last = step_last(irq_mode, cls_q, cond_q, mcyc);

    // Latch class and condition, step the cycle count, pick next sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcyc     <= '0;
            cls_q    <= CL_MOVE;
            cond_q   <= 1'b0;
            irq_mode <= 1'b0;
        end else begin
            if (ph_idx == DEC_PH && mcyc == '0 && !irq_mode) cls_q <= op_class;
            if (ph_idx == DEC_PH && mcyc == MCYC_W'(1))        cond_q <= cond_met;
            if (ph_last) begin
                if (last) begin
                    mcyc     <= '0;
                    irq_mode <= irq_req;
                end else begin
                    mcyc <= mcyc + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mseq_slot.sv
// Slot decoder: turns the cycle kind and phase into bus enables, address
// source, fetch flag and done pulse. Outputs are forced low in reset.
module mseq_slot
    import mseq_pkg::*;
#(
    parameter int NUM_PH = 4,
    localparam int PH_W  = $clog2(NUM_PH)
) (
    input  logic            rst_n,
    input  logic [PH_W-1:0] ph_idx,
    input  logic            ph_last,
    input  mkind_t          kind,
    input  logic            last,
    output logic            rd_en,
    output logic            rd_latch,
    output logic            wr_en,
    output logic [1:0]      addr_sel,
    output logic            op_fetch,
    output logic            done
);

    localparam logic [PH_W-1:0] CAP_PH = PH_W'(NUM_PH - 2);

    logic is_rd;

    // Classify the cycle and gate every strobe with reset.
    always_comb begin
        is_rd    = (kind == K_FETCH) || (kind == K_RDPC) || (kind == K_RDSP);
        rd_en    = rst_n && is_rd && !ph_last;
        rd_latch = rst_n && is_rd && (ph_idx == CAP_PH);
        wr_en    = rst_n && (kind == K_WRSP) && ph_last;
        op_fetch = rst_n && (kind == K_FETCH);
        done     = rst_n && last && ph_last;
        case (kind)
            K_FETCH, K_RDPC: addr_sel = AS_PC;
            K_RDSP, K_WRSP:  addr_sel = AS_SP;
            default:         addr_sel = AS_NONE;
        endcase
    end

endmodule

// File: rtl/mcycle_seq.sv
// Machine-cycle bus timing sequencer top: phase counter, cycle tracker
// and slot decoder. Expects class and condition from an outside decoder.
module mcycle_seq
    import mseq_pkg::*;
#(
    parameter int NUM_PH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_class,
    input  logic              cond_met,
    input  logic              irq_req,
    output logic [NUM_PH-1:0] phase,
    output logic [MCYC_W-1:0] mcyc,
    output logic              rd_en,
    output logic              rd_latch,
    output logic              wr_en,
    output logic [1:0]        addr_sel,
    output logic              op_fetch,
    output logic              done
);

    localparam int PH_W = $clog2(NUM_PH);

    logic [PH_W-1:0] ph_idx;
    logic            ph_last;
    mkind_t          kind;
    logic            last;

    mseq_phase #(.NUM_PH(NUM_PH)) u_phase (
        .clk(clk), .rst_n(rst_n), .ph_idx(ph_idx),
        .ph_strobe(phase), .ph_last(ph_last)
    );

    mseq_track #(.NUM_PH(NUM_PH)) u_track (
        .clk(clk), .rst_n(rst_n), .ph_idx(ph_idx), .ph_last(ph_last),
        .op_class(op_class), .cond_met(cond_met), .irq_req(irq_req),
        .mcyc(mcyc), .kind(kind), .last(last)
    );

    mseq_slot #(.NUM_PH(NUM_PH)) u_slot (
        .rst_n(rst_n), .ph_idx(ph_idx), .ph_last(ph_last), .kind(kind),
        .last(last), .rd_en(rd_en), .rd_latch(rd_latch), .wr_en(wr_en),
        .addr_sel(addr_sel), .op_fetch(op_fetch), .done(done)
    );

endmodule

// File: rtl/mcycle_seq_chk.sv
// Property checker for mcycle_seq, attached by bind. Assumes four phases.
module mcycle_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_req,
    input logic [3:0] phase,
    input logic [2:0] mcyc,
    input logic       rd_en,
    input logic       rd_latch,
    input logic       wr_en,
    input logic [1:0] addr_sel,
    input logic       op_fetch,
    input logic       done
);

    assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);
    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase[3] |=> phase[0]);
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase[0] |=> phase[1]);
    assert_mcyc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !phase[3] |=> $stable(mcyc));
    assert_reset_quiet_R2: assert property (@(posedge clk)
        !rst_n |-> !rd_en && !wr_en && !rd_latch && !done && !op_fetch);
    assert_slot_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
    assert_wr_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> phase[3] && addr_sel == 2'd1);
    assert_latch_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_latch |-> rd_en && phase[2]);
    assert_irq_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && irq_req |=> !op_fetch && addr_sel == 2'd2);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_sel == 2'd2 |-> !rd_en && !wr_en);
    assert_done_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> phase[3]);
    assert_done_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> mcyc == 3'd0 && phase[0]);

endmodule

bind mcycle_seq mcycle_seq_chk u_chk (.*);

// File: tb/mcycle_seq_bench.sv
`timescale 1ns/1ps
module mcycle_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_class = 3'd0;
    logic       cond_met = 1'b0;
    logic       irq_req = 1'b0;
    logic [3:0] phase;
    logic [2:0] mcyc;
    logic       rd_en, rd_latch, wr_en, op_fetch, done;
    logic [1:0] addr_sel;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    mcycle_seq u_mcycle_seq (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .cond_met(cond_met),
        .irq_req(irq_req), .phase(phase), .mcyc(mcyc), .rd_en(rd_en),
        .rd_latch(rd_latch), .wr_en(wr_en), .addr_sel(addr_sel),
        .op_fetch(op_fetch), .done(done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Cycle kinds: 0 fetch, 1 PC read, 2 SP read, 3 SP write, 4 idle.
    function automatic int exp_len(input bit irq, input int cls, input bit c);
        if (irq) return 5;
        case (cls)
            1, 2:    return 2;
            3:       return 4;
            4:       return c ? 5 : 2;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_kind(input bit irq, input int cls, input int m);
        if (irq) return (m == 2 || m == 3) ? 3 : 4;
        if (m == 0) return 0;
        case (cls)
            1:       return 1;
            2:       return 0;
            3:       return (m == 1) ? 4 : 3;
            4:       return (m == 2 || m == 3) ? 2 : 4;
            default: return 4;
        endcase
    endfunction

    function automatic string cls_tag(input bit irq, input int cls);
        if (irq) return "R9";
        case (cls)
            2:       return "R6";
            3:       return "R7";
            4:       return "R8";
            default: return "R5";
        endcase
    endfunction

    // Run one instruction from mcyc 0 phase 0; disturb inputs after sampling (R4).
    task automatic run_instr(input bit irq, input int cls, input bit c, input bit irq_next);
        int len;
        string tg;
        len = exp_len(irq, cls, c);
        tg = cls_tag(irq, cls);
        op_class = 3'(cls);
        cond_met = c;
        irq_req = irq_next;
        for (int m = 0; m < len; m++) begin
            for (int p = 0; p < 4; p++) begin
                int k;
                bit rdk;
                k = exp_kind(irq, cls, m);
                rdk = (k <= 2);
                if (m == 0 && p == 2) op_class = 3'(cls) ^ 3'b111; // R4: late change ignored
                if (m == 1 && p == 2) cond_met = !c;
                #1;
                chk("R1", "phase", int'(phase), 1 << p);
                chk("R1", "mcyc", int'(mcyc), m);
                chk(tg, "addr_sel", int'(addr_sel), (k <= 1) ? 0 : (k <= 3) ? 1 : 2);
                chk(tg, "op_fetch", int'(op_fetch), int'(k == 0));
                chk(k == 4 ? "R10" : "R3", "rd_en", int'(rd_en), int'(rdk && p != 3));
                chk(k == 4 ? "R10" : "R3", "rd_latch", int'(rd_latch), int'(rdk && p == 2));
                chk(k == 4 ? "R10" : "R3", "wr_en", int'(wr_en), int'(k == 3 && p == 3));
                chk("R11", "done", int'(done), int'(m == len - 1 && p == 3));
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R2", "reset phase", int'(phase), 1);
        chk("R2", "reset mcyc", int'(mcyc), 0);
        chk("R2", "reset rd_en", int'(rd_en), 0);
        chk("R2", "reset wr_en", int'(wr_en), 0);
        chk("R2", "reset done", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // Sweep: interrupt flag x class code x condition.
        for (int k = 0; k < 32; k++) begin
            bit irq, c, nxt;
            int cls;
            irq = k[4];
            cls = (k >> 1) & 7;
            c = k[0];
            nxt = (k == 31) ? 1'b0 : ((k + 1) >> 4) != 0;
            run_instr(irq, cls, c, nxt);
        end
        // R2: reset in the middle of a push.
        op_class = 3'd3;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R2", "mid-reset rd_en", int'(rd_en), 0);
        chk("R2", "mid-reset wr_en", int'(wr_en), 0);
        chk("R2", "mid-reset op_fetch", int'(op_fetch), 0);
        repeat (2) @(negedge clk);
        #1;
        chk("R2", "mid-reset phase", int'(phase), 1);
        chk("R2", "mid-reset mcyc", int'(mcyc), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_instr(1'b0, 3, 1'b0, 1'b0);
        run_instr(1'b0, 4, 1'b1, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule